// File: doc/BRIEF.md
# Frequency Lock Detector with Loop Mode Selection

This block watches how far a recovered oscillator, already divided down to the nominal reference frequency, drifts from a reference clock. Both clocks nominally run at 1/64 of the line data rate. It counts edges of each clock over a fixed window of reference cycles. At the end of every window it checks whether the magnitude of the count difference exceeds a tolerance. The tolerance corresponds to either 500 ppm or 2000 ppm, picked by an input.

The result drives a one-bit loop mode select. Low routes the phase-frequency detector into the loop, which pulls the oscillator back in. High routes the bang-bang data phase detector into the loop, for data recovery. LOCK shows which detector is currently in the loop. It stays high for as long as the error stays inside the bound. It alternates while the loop hunts in and out of range.

The oscillator count crosses into the reference domain as a Gray code. The first window after reset only sets the baseline count. Monitoring then continues window after window with no one-shot decision.

Top module: `freq_lock_detector`

## Requirements
- R1: While reset is held and after it is released, until the first comparison, mode_sel is 0 (phase-frequency detector), lock is 0 and win_done is 0.
- R2: A window lasts 2^WIN_LOG2 reference cycles. The first window after reset only captures a baseline. From the second window on, win_done is high for exactly one reference cycle at the end of every window, so successive pulses are 2^WIN_LOG2 cycles apart.
- R3: The tolerance in counts is round(2^WIN_LOG2 × ppm / 10^6): 33 for 500 ppm and 131 for 2000 ppm at the default window. thr_sel = 0 selects the 500 ppm value and thr_sel = 1 the 2000 ppm value. thr_sel is sampled at the window boundary.
- R4: When the magnitude of (divided-clock edges − reference cycles) in a window is at most the selected tolerance, mode_sel becomes 1 (bang-bang detector) in the cycle win_done is high.
- R5: When the magnitude exceeds the tolerance, whether the oscillator is fast or slow, mode_sel becomes 0 in the cycle win_done is high.
- R6: mode_sel and lock change only in a cycle where win_done is high.
- R7: lock is high exactly when mode_sel is 1, and low exactly when mode_sel is 0.
- R8: The decision is remade every window. A locked loop whose error grows beyond the tolerance drops back to acquisition, and a loop that returns within tolerance locks again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock; the block's main clock domain |
| clk_div | input | 1 | Divided recovered oscillator clock, asynchronous to clk_ref |
| rst | input | 1 | Synchronous active-high reset, in the clk_ref domain |
| thr_sel | input | 1 | Tolerance select: 0 = 500 ppm, 1 = 2000 ppm |
| mode_sel | output | 1 | 0 = phase-frequency detector in loop, 1 = bang-bang detector in loop |
| lock | output | 1 | High while the bang-bang detector is in the loop |
| win_done | output | 1 | One-cycle strobe when a comparison completes |

## Verification
The assertions assume that clk_div runs steadily and continuously, so that its edge count per window stays within a few percent of the window length. They also assume that reset lasts several cycles of both clocks. The bench generates clk_div from a fractional period at a chosen ppm offset, and keeps that offset steady for at least one full window before it samples a decision. The bench tests only at offsets well clear of each tolerance: 0, ±1200 and ±5000 ppm. This keeps the ±1 count uncertainty of the clock-crossing sample from flipping an expected result.

// File: rtl/fld_pkg.sv
package fld_pkg;

    typedef enum logic {
        LOOP_ACQ   = 1'b0,
        LOOP_TRACK = 1'b1
    } loop_mode_e;

    typedef struct packed {
        logic valid;
        logic in_bound;
    } verdict_t;

    // Tolerance in counts for a window of win cycles, rounded to nearest.
    function automatic int unsigned ppm_to_counts(input longint unsigned win,
                                                  input longint unsigned ppm);
        longint unsigned prod;
        prod = win * ppm + 64'd500000;
        return int'(prod / 64'd1000000);
    endfunction

endpackage

// File: rtl/fld_div_counter.sv
module fld_div_counter #(
    parameter int CNT_W = 18
) (
    input  logic             clk_div,
    input  logic             rst,
    output logic [CNT_W-1:0] gray_o
);
    logic             rst_meta, rst_div;
    logic [CNT_W-1:0] bin_q;

    always_ff @(posedge clk_div) begin
        rst_meta <= rst;
        rst_div  <= rst_meta;
    end

    always_ff @(posedge clk_div) begin
        if (rst_div) begin
            bin_q  <= '0;
            gray_o <= '0;
        end else begin
            bin_q  <= bin_q + 1'b1;
            gray_o <= (bin_q + 1'b1) ^ ((bin_q + 1'b1) >> 1);
        end
    end
endmodule

// File: rtl/fld_gray_sync.sv
module fld_gray_sync #(
    parameter int CNT_W = 18
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] gray_i,
    output logic [CNT_W-1:0] bin_o
);
    logic [CNT_W-1:0] s1_q, s2_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q <= '0;
            s2_q <= '0;
        end else begin
            s1_q <= gray_i;
            s2_q <= s1_q;
        end
    end

    always_comb begin
        for (int i = 0; i < CNT_W; i++) begin
            bin_o[i] = ^(s2_q >> i);
        end
    end
endmodule

// File: rtl/fld_window_cmp.sv
module fld_window_cmp
    import fld_pkg::*;
#(
    parameter int WIN_LOG2 = 16,
    parameter int CNT_W    = 18,
    parameter int THR_LO   = 33,
    parameter int THR_HI   = 131
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             thr_sel,
    input  logic [CNT_W-1:0] div_bin,
    output verdict_t         verdict_o
);
    localparam int DW = CNT_W + 1;
    localparam logic signed [DW-1:0] WIN_S = DW'(2 ** WIN_LOG2);

    logic [WIN_LOG2-1:0]     win_cnt;
    logic                    primed;
    logic [CNT_W-1:0]        base_q;
    logic [CNT_W-1:0]        delta;
    logic signed [DW-1:0]    diff;
    logic [DW-1:0]           mag;
    logic [DW-1:0]           thr;
    logic                    at_end;

    assign at_end = &win_cnt;
    assign delta  = div_bin - base_q;
    assign diff   = signed'({1'b0, delta}) - WIN_S;
    assign mag    = diff[DW-1] ? DW'(-diff) : DW'(diff);
    assign thr    = thr_sel ? DW'(THR_HI) : DW'(THR_LO);

    always_ff @(posedge clk) begin
        if (rst) begin
            win_cnt   <= '0;
            primed    <= 1'b0;
            base_q    <= '0;
            verdict_o <= '0;
        end else begin
            win_cnt         <= win_cnt + 1'b1;
            verdict_o.valid <= 1'b0;
            if (at_end) begin
                base_q <= div_bin;
                primed <= 1'b1;
                if (primed) begin
                    verdict_o.valid    <= 1'b1;
                    verdict_o.in_bound <= (mag <= thr);
                end
            end
        end
    end
endmodule

// File: rtl/freq_lock_detector.sv
module freq_lock_detector
    import fld_pkg::*;
#(
    parameter int WIN_LOG2 = 16,
    parameter int PPM_LO   = 500,
    parameter int PPM_HI   = 2000
) (
    input  logic clk_ref,
    input  logic clk_div,
    input  logic rst,
    input  logic thr_sel,
    output logic mode_sel,
    output logic lock,
    output logic win_done
);
    localparam int CNT_W  = WIN_LOG2 + 2;
    localparam int THR_LO = ppm_to_counts(64'(2 ** WIN_LOG2), 64'(PPM_LO));
    localparam int THR_HI = ppm_to_counts(64'(2 ** WIN_LOG2), 64'(PPM_HI));

    logic [CNT_W-1:0] div_gray, div_bin;
    verdict_t         verdict;
    loop_mode_e       mode_q;
    logic             done_q;

    fld_div_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk_div (clk_div),
        .rst     (rst),
        .gray_o  (div_gray)
    );

    fld_gray_sync #(.CNT_W(CNT_W)) u_sync (
        .clk    (clk_ref),
        .rst    (rst),
        .gray_i (div_gray),
        .bin_o  (div_bin)
    );

    fld_window_cmp #(
        .WIN_LOG2 (WIN_LOG2),
        .CNT_W    (CNT_W),
        .THR_LO   (THR_LO),
        .THR_HI   (THR_HI)
    ) u_cmp (
        .clk       (clk_ref),
        .rst       (rst),
        .thr_sel   (thr_sel),
        .div_bin   (div_bin),
        .verdict_o (verdict)
    );

    always_ff @(posedge clk_ref) begin
        if (rst) begin
            mode_q <= LOOP_ACQ;
            done_q <= 1'b0;
        end else begin
            done_q <= verdict.valid;
            if (verdict.valid) begin
                mode_q <= verdict.in_bound ? LOOP_TRACK : LOOP_ACQ;
            end
        end
    end

    assign mode_sel = mode_q;
    assign lock     = (mode_q == LOOP_TRACK);
    assign win_done = done_q;
endmodule

// File: rtl/fld_checker.sv
module fld_checker #(
    parameter int WIN_LOG2 = 16
) (
    input logic clk_ref,
    input logic rst,
    input logic mode_sel,
    input logic lock,
    input logic win_done
);
    localparam int GW = WIN_LOG2 + 1;
    logic [GW-1:0] gap;
    logic          seen;

    always_ff @(posedge clk_ref) begin
        if (rst) begin
            gap  <= '0;
            seen <= 1'b0;
        end else if (win_done) begin
            gap  <= '0;
            seen <= 1'b1;
        end else begin
            gap  <= gap + 1'b1;
        end
    end

    a_r1_reset_state: assert property (@(posedge clk_ref)
        rst |=> (!mode_sel && !lock && !win_done));

    a_r2_done_one_cycle: assert property (@(posedge clk_ref) disable iff (rst)
        win_done |=> !win_done);

    a_r2_done_spacing: assert property (@(posedge clk_ref) disable iff (rst)
        (win_done && seen) |-> (gap == GW'(2 ** WIN_LOG2 - 1)));

    a_r6_mode_only_at_done: assert property (@(posedge clk_ref) disable iff (rst)
        !win_done |-> ($stable(mode_sel) && $stable(lock)));

    a_r7_lock_matches_mode: assert property (@(posedge clk_ref) disable iff (rst)
        lock == mode_sel);
endmodule

bind freq_lock_detector fld_checker #(.WIN_LOG2(WIN_LOG2)) u_fld_chk (
    .clk_ref  (clk_ref),
    .rst      (rst),
    .mode_sel (mode_sel),
    .lock     (lock),
    .win_done (win_done)
);

// File: tb/sim_freq_lock_detector.sv
`timescale 1ns/1fs
module sim_freq_lock_detector;
    localparam int WIN_LOG2 = 12;
    localparam int WIN      = 2 ** WIN_LOG2;

    logic clk_ref = 1'b0;
    logic clk_div = 1'b0;
    logic rst     = 1'b1;
    logic thr_sel = 1'b0;
    logic mode_sel, lock, win_done;
    real  ppm     = 0.0;
    int   total   = 0;
    int   bad     = 0;
    bit   finished = 1'b0;

    freq_lock_detector #(.WIN_LOG2(WIN_LOG2)) u0 (
        .clk_ref  (clk_ref),
        .clk_div  (clk_div),
        .rst      (rst),
        .thr_sel  (thr_sel),
        .mode_sel (mode_sel),
        .lock     (lock),
        .win_done (win_done)
    );

    always #2 clk_ref = ~clk_ref;

    initial begin
        #1.3;
        forever begin
            #(2.0 / (1.0 + ppm * 1.0e-6));
            clk_div = ~clk_div;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Returns number of negedges waited until win_done is seen high.
    task automatic wait_done(output int waited);
        waited = 0;
        do begin
            @(negedge clk_ref);
            waited++;
        end while (!win_done && waited < 3 * WIN);
    endtask

    task automatic settle_and_check(input real p, input bit sel, input bit exp_lock,
                                    input string req);
        int w;
        ppm     = p;
        thr_sel = sel;
        wait_done(w);
        wait_done(w);
        check(win_done == 1'b1, req, int'(win_done), 1);
        check(mode_sel == exp_lock, req, int'(mode_sel), int'(exp_lock));
        check(lock == exp_lock, {req, "/R7"}, int'(lock), int'(exp_lock));
    endtask

    task automatic t_reset();
        repeat (5) @(negedge clk_ref);
        check(!mode_sel && !lock && !win_done, "R1 during reset",
              int'({mode_sel, lock, win_done}), 0);
        rst = 1'b0;
        repeat (WIN + 10) @(negedge clk_ref);
        check(!mode_sel && !lock && !win_done, "R1 first window",
              int'({mode_sel, lock, win_done}), 0);
    endtask

    task automatic t_spacing();
        int w;
        wait_done(w);
        @(negedge clk_ref);
        check(win_done == 1'b0, "R2 single-cycle strobe", int'(win_done), 0);
        wait_done(w);
        check(w == WIN - 1, "R2 strobe spacing", w + 1, WIN);
    endtask

    task automatic t_hold_between();
        int w;
        logic m0;
        wait_done(w);
        m0 = mode_sel;
        repeat (WIN / 2) @(negedge clk_ref);
        check(mode_sel == m0 && lock == m0, "R6 no change mid-window",
              int'(mode_sel), int'(m0));
    endtask

    initial begin
        t_reset();
        t_spacing();
        settle_and_check(0.0, 1'b0, 1'b1, "R4 zero error, 500ppm");
        t_hold_between();
        settle_and_check(5000.0, 1'b0, 1'b0, "R5 fast +5000ppm");
        settle_and_check(0.0, 1'b0, 1'b1, "R8 relock after error");
        settle_and_check(-5000.0, 1'b0, 1'b0, "R5 slow -5000ppm");
        settle_and_check(1200.0, 1'b0, 1'b0, "R3 1200ppm over 500ppm bound");
        settle_and_check(1200.0, 1'b1, 1'b1, "R3 1200ppm within 2000ppm bound");
        settle_and_check(-1200.0, 1'b1, 1'b1, "R3 -1200ppm within 2000ppm bound");
        settle_and_check(5000.0, 1'b1, 1'b0, "R8 loss while wide bound");
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk_ref);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule